// File: doc/BRIEF.md
# Parallel Flash Command Front End

This block models the control side of a parallel flash memory. Four active-low pins select the bus cycle: `rp_n` for reset and power-down, `ce_n` for chip select, `oe_n` for output enable and `we_n` for write enable. The decoded cycle is one of read, output disable, standby, reset or write. The block drives the data bus only during a read. Each write pulse hands one command byte to an interpreter. The interpreter chooses what a read returns (memory words, the status byte or the identifier codes). It also starts program and erase jobs on a small write engine.

Two inputs decide whether a program or erase may go ahead:
- `vpp_below` says the programming supply is under its lockout level. While it is high, only the read, status and clear commands still do anything.
- `prot_release` must be high before the lowest blocks may be altered.

Failed or malformed jobs set sticky error flags in the status byte.

The memory is a small internal RAM divided into equal blocks. Data width, depth, block size, number of protected blocks and job durations are parameters.

Top module: `flash_front_end`

## Requirements
- R1: With `rp_n` low, the bus is not driven on the following cycle. The read selection returns to memory words and every error flag clears.
- R2: A read cycle (`rp_n`=1, `ce_n`=0, `oe_n`=0, `we_n`=1) asserts `dq_oe` one cycle later, with the word for the current read selection on `dq_out`.
- R3: Standby (`ce_n`=1) and output disable (`ce_n`=0, `oe_n`=1, `we_n`=1) leave `dq_oe` low one cycle later. `dq_out` is all zeros whenever `dq_oe` is low.
- R4: A write cycle (`ce_n`=0, `oe_n`=1, `we_n`=0) captures exactly one command from `dq_in[7:0]` and `addr`, on its first cycle, however long `we_n` stays low.
- R5: Commands set what a read returns:
  - 0xFF: memory words.
  - 0x70: the status byte, zero-extended.
  - 0x90: identifier. Address 0 returns `MFR_CODE`, address 1 returns `DEV_CODE`, and every other address returns zero.
- R6: Command 0x40 followed by a data write programs the word at the data write's address to old AND data. The read selection becomes status.
- R7: Command 0x20 followed by 0xD0 sets every word of the addressed block to all ones. Any other second byte sets status bits 5 and 4 and erases nothing. Either way, the read selection becomes status.
- R8: Status bit 7 reads 0 while a job runs, for `PROG_CYC` cycles for a program and `ERASE_CYC` cycles for an erase, counted from the launching write edge. Writes made while a job runs are ignored.
- R9: With `vpp_below` high, program and erase change no memory. They set status bit 3 together with bit 4 (program) or bit 5 (erase). Read, status, clear and identifier commands still work.
- R10: Blocks with index below `NUM_LOCKED` can be programmed or erased only while `prot_release` is high. Otherwise the job is refused and status bit 1 is set, together with bit 4 or bit 5. Other blocks ignore `prot_release`.
- R11: Status layout: bit 7 = ready, bit 5 = erase error, bit 4 = program error, bit 3 = supply error, bit 1 = protection error; all other bits are zero. Error bits stay set until command 0x50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rp_n | input | 1 | Reset/power-down, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Word address |
| dq_in | input | DW | Data bus, inbound |
| dq_out | output | DW | Data bus, outbound |
| dq_oe | output | 1 | High when the block drives the data bus |
| vpp_below | input | 1 | Programming supply below lockout level |
| prot_release | input | 1 | High allows changes to protected blocks |

## Verification
If the read selection is wrong, the very next read cycle returns the wrong source. A pending-sequence error shows up at a later write, when a data word is taken as a command or the reverse. A wrong busy count or erase walk changes the number of busy status samples the bench sees. It also leaves block words that are not all ones after the job. Error flags that are wrongly kept or wrongly dropped show up in the next status read.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef enum logic [2:0] {
    BUS_RESET,
    BUS_READ,
    BUS_ODIS,
    BUS_STBY,
    BUS_WRITE
  } bus_mode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_STATUS,
    SRC_IDENT
  } rd_src_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_PROG,
    SEQ_ERASE
  } seq_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STAT = 8'h50;
  localparam logic [7:0] CMD_READ_IDENT = 8'h90;
  localparam logic [7:0] CMD_PROG_SETUP = 8'h40;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
  import flash_fe_pkg::*;
(
  input  logic      rp_n,
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  output bus_mode_e mode
);

  always_comb begin
    if (!rp_n)                mode = BUS_RESET;
    else if (ce_n)            mode = BUS_STBY;
    else if (!oe_n && we_n)   mode = BUS_READ;
    else if (oe_n && !we_n)   mode = BUS_WRITE;
    else                      mode = BUS_ODIS;  // both strobes low or both high
  end

endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/flash_wsm.sv
module flash_wsm #(
  parameter int DW        = 16,
  parameter int AW        = 5,
  parameter int BLK_AW    = 3,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          go,
  input  logic          go_erase,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] rmw_addr,
  input  logic [DW-1:0] rmw_data
);

  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0]   cnt;
  logic [BLK_AW:0] idx;
  logic            erase_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy    <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      erase_q <= 1'b0;
    end else if (go) begin
      busy    <= 1'b1;
      cnt     <= go_erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
      idx     <= '0;
      erase_q <= go_erase;
      addr_q  <= go_addr;
      data_q  <= go_data;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
      if (erase_q && !idx[BLK_AW]) idx <= idx + 1'b1;
    end
  end

  assign rmw_addr = addr_q;

  always_comb begin
    mem_we    = busy && (erase_q ? !idx[BLK_AW] : (cnt == CW'(1)));
    mem_waddr = erase_q ? {addr_q[AW-1:BLK_AW], idx[BLK_AW-1:0]} : addr_q;
    mem_wdata = erase_q ? '1 : (rmw_data & data_q);
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_fe_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 5,
  parameter int BLK_AW     = 3,
  parameter int NUM_LOCKED = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rst,
  input  logic          wr_stb,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          vpp_below,
  input  logic          prot_release,
  input  logic          busy,
  output rd_src_e       rd_src,
  output logic [7:0]    status,
  output logic          go,
  output logic          go_erase
);

  seq_e       seq;
  logic       err_erase, err_prog, err_vpp, err_lock;
  logic [7:0] cmd;
  logic       in_block_prot, blocked, take, confirm;

  always_comb begin
    cmd           = cmd_data[7:0];
    in_block_prot = int'(cmd_addr[AW-1:BLK_AW]) < NUM_LOCKED;
    blocked       = in_block_prot && !prot_release;
    take          = wr_stb && !busy;
    confirm       = (seq == SEQ_PROG) || ((seq == SEQ_ERASE) && (cmd == CMD_CONFIRM));
    go            = take && confirm && !vpp_below && !blocked;
    go_erase      = (seq == SEQ_ERASE);
    status        = {!busy, 1'b0, err_erase, err_prog, err_vpp, 1'b0, err_lock, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      seq       <= SEQ_IDLE;
      rd_src    <= SRC_ARRAY;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_vpp   <= 1'b0;
      err_lock  <= 1'b0;
    end else if (take) begin
      unique case (seq)
        SEQ_PROG: begin
          seq    <= SEQ_IDLE;
          rd_src <= SRC_STATUS;
          if (vpp_below) begin
            err_vpp  <= 1'b1;
            err_prog <= 1'b1;
          end else if (blocked) begin
            err_lock <= 1'b1;
            err_prog <= 1'b1;
          end
        end
        SEQ_ERASE: begin
          seq    <= SEQ_IDLE;
          rd_src <= SRC_STATUS;
          if (cmd != CMD_CONFIRM) begin
            err_prog  <= 1'b1;
            err_erase <= 1'b1;
          end else if (vpp_below) begin
            err_vpp   <= 1'b1;
            err_erase <= 1'b1;
          end else if (blocked) begin
            err_lock  <= 1'b1;
            err_erase <= 1'b1;
          end
        end
        default: begin
          case (cmd)
            CMD_READ_ARRAY: rd_src <= SRC_ARRAY;
            CMD_READ_STAT:  rd_src <= SRC_STATUS;
            CMD_READ_IDENT: rd_src <= SRC_IDENT;
            CMD_CLEAR_STAT: begin
              err_erase <= 1'b0;
              err_prog  <= 1'b0;
              err_vpp   <= 1'b0;
              err_lock  <= 1'b0;
            end
            CMD_PROG_SETUP: begin
              seq    <= SEQ_PROG;
              rd_src <= SRC_STATUS;
            end
            CMD_ERASE_SET: begin
              seq    <= SEQ_ERASE;
              rd_src <= SRC_STATUS;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_front_end.sv
module flash_front_end
  import flash_fe_pkg::*;
#(
  parameter int          DW         = 16,
  parameter int          AW         = 5,
  parameter int          BLK_AW     = 3,
  parameter int          NUM_LOCKED = 1,
  parameter int          PROG_CYC   = 6,
  parameter int          ERASE_CYC  = 12,
  parameter logic [15:0] MFR_CODE   = 16'h00A7,
  parameter logic [15:0] DEV_CODE   = 16'h5C3E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rp_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic          vpp_below,
  input  logic          prot_release
);

  localparam logic [DW-1:0] MFR_W = MFR_CODE[DW-1:0];
  localparam logic [DW-1:0] DEV_W = DEV_CODE[DW-1:0];

  bus_mode_e     mode;
  rd_src_e       rd_src, sel_q;
  logic          wr_prev, wr_stb, bus_rst;
  logic          wsm_busy, go, go_erase;
  logic [7:0]    status_byte;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, rmw_addr;
  logic [DW-1:0] mem_wdata, rmw_data, arr_rd, id_q;

  flash_bus_decode u_dec (
    .rp_n (rp_n), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n), .mode (mode)
  );

  assign bus_rst = (mode == BUS_RESET);
  assign wr_stb  = (mode == BUS_WRITE) && !wr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      dq_oe   <= 1'b0;
      sel_q   <= SRC_ARRAY;
      id_q    <= '0;
    end else begin
      wr_prev <= (mode == BUS_WRITE);
      dq_oe   <= (mode == BUS_READ);
      sel_q   <= rd_src;
      id_q    <= (addr == AW'(0)) ? MFR_W : ((addr == AW'(1)) ? DEV_W : '0);
    end
  end

  flash_cmd_ctrl #(
    .DW (DW), .AW (AW), .BLK_AW (BLK_AW), .NUM_LOCKED (NUM_LOCKED)
  ) u_cmd (
    .clk          (clk),
    .rst          (rst),
    .bus_rst      (bus_rst),
    .wr_stb       (wr_stb),
    .cmd_addr     (addr),
    .cmd_data     (dq_in),
    .vpp_below    (vpp_below),
    .prot_release (prot_release),
    .busy         (wsm_busy),
    .rd_src       (rd_src),
    .status       (status_byte),
    .go           (go),
    .go_erase     (go_erase)
  );

  flash_wsm #(
    .DW (DW), .AW (AW), .BLK_AW (BLK_AW), .PROG_CYC (PROG_CYC), .ERASE_CYC (ERASE_CYC)
  ) u_wsm (
    .clk       (clk),
    .rst       (rst),
    .abort     (bus_rst),
    .go        (go),
    .go_erase  (go_erase),
    .go_addr   (addr),
    .go_data   (dq_in),
    .busy      (wsm_busy),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .rmw_addr  (rmw_addr),
    .rmw_data  (rmw_data)
  );

  flash_array #(.DW (DW), .AW (AW)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (addr),
    .rdata_a (arr_rd),
    .raddr_b (rmw_addr),
    .rdata_b (rmw_data)
  );

  always_comb begin
    dq_out = '0;
    if (dq_oe) begin
      unique case (sel_q)
        SRC_STATUS: dq_out = DW'(status_byte);
        SRC_IDENT:  dq_out = id_q;
        default:    dq_out = arr_rd;
      endcase
    end
  end

endmodule

// File: rtl/flash_front_end_chk.sv
module flash_front_end_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rp_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic          vpp_below,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic          busy,
  input logic          wr_stb,
  input logic [7:0]    status
);

  // R1
  rp_tristate_chk: assert property (@(posedge clk) disable iff (rst)
    !rp_n |=> !dq_oe);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (rp_n && !ce_n && !oe_n && we_n) |=> dq_oe);

  // R3
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rp_n && ce_n) |=> !dq_oe);

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> (dq_out == '0));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_stb) |=> $stable(status[5:1]));

  // R9
  lockout_launch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(vpp_below));

endmodule

bind flash_front_end flash_front_end_chk #(.DW (DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rp_n      (rp_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .vpp_below (vpp_below),
  .dq_oe     (dq_oe),
  .dq_out    (dq_out),
  .busy      (wsm_busy),
  .wr_stb    (wr_stb),
  .status    (status_byte)
);

// File: tb/flash_front_end_test.sv
module flash_front_end_test;

  localparam int DW        = 16;
  localparam int AW        = 5;
  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic          vpp_below = 1'b0;
  logic          prot_release = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  flash_front_end #(
    .DW (DW), .AW (AW), .PROG_CYC (PROG_CYC), .ERASE_CYC (ERASE_CYC)
  ) uut (
    .clk (clk), .rst (rst), .rp_n (rp_n), .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
    .addr (addr), .dq_in (dq_in), .dq_out (dq_out), .dq_oe (dq_oe),
    .vpp_below (vpp_below), .prot_release (prot_release)
  );

  task automatic check(input bit ok, input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pins(input logic rp, input logic ce, input logic oe, input logic we,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    rp_n = rp; ce_n = ce; oe_n = oe; we_n = we; addr = a; dq_in = d;
  endtask

  // monitor: pops one expected item per armed cycle, compares after the edge
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [DW:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      #2;
      check({dq_oe, dq_out} === e, t, {dq_oe, dq_out}, e);
    end
  end

  task automatic wr_hold(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n);
    @(negedge clk);
    pins(1, 0, 1, 0, a, d);
    repeat (n) @(negedge clk);
    pins(1, 1, 1, 1, a, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_hold(a, d, 1);
  endtask

  task automatic cyc_exp(input logic rp, input logic ce, input logic oe, input logic we,
                         input logic [AW-1:0] a, input logic eoe, input logic [DW-1:0] ed,
                         input string tag);
    @(negedge clk);
    pins(rp, ce, oe, we, a, '0);
    exp_q.push_back({eoe, ed});
    tag_q.push_back(tag);
    @(negedge clk);
    pins(1, 1, 1, 1, a, '0);
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input logic [DW-1:0] ed, input string tag);
    cyc_exp(1, 0, 0, 1, a, 1'b1, ed, tag);
  endtask

  // called right after wr returns: counts status samples with the ready bit low
  task automatic wait_ready(output int n);
    pins(1, 0, 0, 1, '0, '0);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (dq_out[7]) break;
      n++;
    end
    pins(1, 1, 1, 1, '0, '0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state and status layout
    cyc_exp(1, 1, 0, 1, 0, 1'b0, '0, "R3 reset state quiet");
    wr(0, 16'h0070);
    rd_exp(0, 16'h0080, "R11 idle status");
    rd_exp(0, 16'h0080, "R2 read drives bus");

    // identifier reads
    wr(0, 16'h0090);
    rd_exp(0, 16'h00A7, "R5 manufacturer code");
    rd_exp(1, 16'h5C3E, "R5 device code");
    rd_exp(6, 16'h0000, "R5 other identifier address");

    // bus modes without drive
    cyc_exp(1, 0, 1, 1, 0, 1'b0, '0, "R3 output disable");
    cyc_exp(1, 1, 1, 1, 0, 1'b0, '0, "R3 standby");
    cyc_exp(0, 0, 0, 1, 0, 1'b0, '0, "R1 reset pin low");

    // erase block 1 (not protected)
    wr(8, 16'h0020);
    wr(8, 16'h00D0);
    wait_ready(n);
    check(n == ERASE_CYC - 1, "R8 erase busy length", DW'(n), DW'(ERASE_CYC - 1));
    rd_exp(0, 16'h0080, "R7 status after erase");
    wr(0, 16'h00FF);
    rd_exp(8, 16'hFFFF, "R7 first block word");
    rd_exp(15, 16'hFFFF, "R7 last block word");

    // program and AND behaviour
    wr(10, 16'h0040);
    wr(10, 16'hA5C3);
    wait_ready(n);
    check(n == PROG_CYC - 1, "R8 program busy length", DW'(n), DW'(PROG_CYC - 1));
    rd_exp(0, 16'h0080, "R6 status mode after program");
    wr(0, 16'h00FF);
    rd_exp(10, 16'hA5C3, "R6 program result");
    wr(10, 16'h0040);
    wr(10, 16'h0FF0);
    wait_ready(n);
    wr(0, 16'h00FF);
    rd_exp(10, 16'h05C0, "R6 program only clears bits");
    rd_exp(9, 16'hFFFF, "R6 neighbour untouched");

    // write during busy is ignored
    wr(11, 16'h0040);
    wr(11, 16'h1234);
    wr(0, 16'h00FF);
    wait_ready(n);
    rd_exp(0, 16'h0080, "R8 write while busy ignored");
    wr(0, 16'h00FF);
    rd_exp(11, 16'h1234, "R6 second word programmed");

    // one command per held write pulse
    wr_hold(12, 16'h0040, 3);
    rd_exp(0, 16'h0080, "R4 held write no job");
    wr(12, 16'h00F0);
    wait_ready(n);
    wr(0, 16'h00FF);
    rd_exp(12, 16'h00F0, "R4 single capture per pulse");

    // supply lockout
    vpp_below = 1'b1;
    wr(10, 16'h0040);
    wr(10, 16'h0000);
    rd_exp(0, 16'h0098, "R9 program lockout status");
    wr(0, 16'h00FF);
    rd_exp(10, 16'h05C0, "R9 memory unchanged");
    wr(0, 16'h0070);
    rd_exp(0, 16'h0098, "R11 error bits sticky");
    wr(0, 16'h0090);
    rd_exp(0, 16'h00A7, "R9 identifier under lockout");
    wr(8, 16'h0020);
    wr(8, 16'h00D0);
    rd_exp(0, 16'h00B8, "R9 erase lockout status");
    wr(0, 16'h0050);
    wr(0, 16'h0070);
    rd_exp(0, 16'h0080, "R11 clear status");
    wr(0, 16'h00FF);
    rd_exp(11, 16'h1234, "R9 block not erased");
    vpp_below = 1'b0;

    // write protection of block 0
    prot_release = 1'b0;
    wr(2, 16'h0020);
    wr(2, 16'h00D0);
    rd_exp(0, 16'h00A2, "R10 erase refused");
    wr(0, 16'h0050);
    wr(3, 16'h0040);
    wr(3, 16'h0000);
    rd_exp(0, 16'h0092, "R10 program refused");
    wr(0, 16'h0050);
    prot_release = 1'b1;
    wr(2, 16'h0020);
    wr(2, 16'h00D0);
    wait_ready(n);
    check(n == ERASE_CYC - 1, "R10 protected erase runs", DW'(n), DW'(ERASE_CYC - 1));
    wr(0, 16'h00FF);
    rd_exp(3, 16'hFFFF, "R10 protected block erased");
    rd_exp(0, 16'hFFFF, "R10 protected block first word");
    prot_release = 1'b0;

    // malformed erase sequence
    wr(8, 16'h0020);
    wr(8, 16'h00FF);
    rd_exp(0, 16'h00B0, "R7 bad confirm status");
    wr(0, 16'h00FF);
    rd_exp(11, 16'h1234, "R7 bad confirm no erase");

    // reset pin clears errors and returns to memory reads
    vpp_below = 1'b1;
    wr(10, 16'h0040);
    wr(10, 16'h0000);
    vpp_below = 1'b0;
    cyc_exp(0, 1, 1, 1, 0, 1'b0, '0, "R1 reset pulse quiet");
    rd_exp(10, 16'h05C0, "R1 memory reads after reset");
    wr(0, 16'h0070);
    rd_exp(0, 16'h0080, "R1 errors cleared");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule